// File: doc/BRIEF.md
# Programmable Rate Divider with Square-Wave and Periodic Event

This block divides a 32.768 kHz time-base enable down through a fifteen-stage binary chain. A four-bit rate code picks one of thirteen chain taps. That one tap drives two outputs. The first is a square-wave output. The second is a one-cycle periodic event pulse that fires each time the tap falls. The last stage also gives a one-cycle pulse once per second. This pulse is meant for the calendar logic that advances the time.

A three-bit oscillator field sets the chain's mode. One pattern runs the chain. A second family of patterns clears the chain and holds it at zero. Every other pattern freezes the chain where it is. Two enables gate the outputs, each on its own: one for the square wave and one for the periodic event. Everything runs in the system clock domain, and the time base arrives as a one-cycle enable.

Top module: `rtc_tap_divider`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `sqw`, `pi_evt` and `sec_tick` are 0 and the chain count is zero.
- R2: With `osc_ctl` = 3'b010 the chain advances by one on each clock edge where `tb_en` is 1, and does not advance when `tb_en` is 0. `sec_tick` is a one-cycle pulse after every 32768th advance, counted from zero.
- R3: With `osc_ctl` = 3'b110 or 3'b111 the chain is cleared to zero and stays there. No pulses are produced. After a return to 3'b010, the first `sec_tick` follows exactly 32768 time-base pulses.
- R4: With any of the patterns 3'b000, 3'b001, 3'b011, 3'b100 or 3'b101 the chain keeps its count and produces no pulses. Counting resumes from that value, so no time is lost or gained.
- R5: Rate code c selects tap k: k = 6 for c = 1 (256 Hz), k = 7 for c = 2 (128 Hz), and k = c-2 for c = 3..15 (8.192 kHz down to 2 Hz). With `sqw_en` = 1, `sqw` equals bit k of the chain count. It starts low after a clear, then spends 2^k time-base pulses low and 2^k high.
- R6: With `pi_en` = 1 and code c nonzero, `pi_evt` is a one-cycle pulse after each advance that brings the low k+1 chain bits to zero. This gives one pulse per 2^(k+1) time-base pulses, equal to the square-wave period.
- R7: `sqw` is 0 whenever `sqw_en` = 0 or the rate code is 0. `pi_evt` stays 0 whenever `pi_en` = 0 or the rate code is 0. The chain and `sec_tick` are unaffected by either enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tb_en | input | 1 | One-cycle 32.768 kHz time-base enable |
| osc_ctl | input | 3 | Oscillator / chain mode pattern |
| rate_sel | input | 4 | Tap select code |
| sqw_en | input | 1 | Square-wave output enable |
| pi_en | input | 1 | Periodic event enable |
| sqw | output | 1 | Square-wave output |
| pi_evt | output | 1 | Periodic event pulse |
| sec_tick | output | 1 | One pulse per second of time base |

## Verification
Some properties are checked by assertions on every cycle:
- a hold pattern leaves the chain at zero on the next cycle;
- a stop pattern leaves it unchanged;
- a second tick only follows a running wrap;
- a periodic event only follows a cycle where it was enabled with a nonzero code, and leaves the selected tap low;
- the square wave stays low while disabled.

The bench's scenarios show the rest. They show the exact tap and period for every rate code, including the two aliased low codes. They show that a frozen chain resumes without losing its place, and that the first second after a hold lasts exactly 32768 pulses.

// File: rtl/rtc_div_pkg.sv
package rtc_div_pkg;

  typedef enum logic [1:0] {
    CH_STOP = 2'd0,
    CH_RUN  = 2'd1,
    CH_HOLD = 2'd2
  } chain_mode_e;

  // Oscillator pattern decode: one run pattern, a hold family, stop otherwise.
  function automatic chain_mode_e decode_osc(input logic [2:0] pat);
    if (pat == 3'b010)
      return CH_RUN;
    else if (pat[2:1] == 2'b11)
      return CH_HOLD;
    else
      return CH_STOP;
  endfunction

  // Rate code to chain tap index; codes 1 and 2 alias lower-rate taps.
  function automatic int tap_of_code(input int code);
    if (code == 1)
      return 6;
    else if (code == 2)
      return 7;
    else
      return code - 2;
  endfunction

endpackage

// File: rtl/rtc_div_chain.sv
module rtc_div_chain
  import rtc_div_pkg::*;
#(
  parameter int STAGES = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tb_en,
  input  chain_mode_e       mode,
  output logic [STAGES-1:0] cnt,
  output logic              wrap_tick
);

  logic [STAGES-1:0] cnt_q, cnt_d;
  logic              tick_q, tick_d;

  always_comb begin
    cnt_d  = cnt_q;
    tick_d = 1'b0;
    case (mode)
      CH_RUN: begin
        if (tb_en) begin
          cnt_d  = cnt_q + 1'b1;
          tick_d = &cnt_q;
        end
      end
      CH_HOLD: cnt_d = '0;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tick_q <= tick_d;
    end
  end

  assign cnt       = cnt_q;
  assign wrap_tick = tick_q;

  // R3: a hold pattern leaves the chain at zero.
  p_hold_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == CH_HOLD) |=> (cnt == '0));

  // R4: a stop pattern keeps the count unchanged.
  p_stop_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == CH_STOP) |=> $stable(cnt));

  // R2: the second tick only follows a running wrap.
  p_tick_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_tick |-> (cnt == '0) && ($past(mode) == CH_RUN) && $past(tb_en));

endmodule

// File: rtl/rtc_tap_sel.sv
module rtc_tap_sel
  import rtc_div_pkg::*;
#(
  parameter int STAGES = 15,
  parameter int RATE_W = 4
) (
  input  logic [STAGES-1:0] cnt,
  input  logic [RATE_W-1:0] rate,
  output logic              tap_bit,
  output logic              tap_full,
  output logic              active
);

  localparam int NCODE = 1 << RATE_W;

  logic [NCODE-1:0] bit_v;
  logic [NCODE-1:0] full_v;

  assign bit_v[0]  = 1'b0;
  assign full_v[0] = 1'b0;

  for (genvar c = 1; c < NCODE; c++) begin : g_code
    localparam int TAP = tap_of_code(c);
    assign bit_v[c]  = cnt[TAP];
    assign full_v[c] = &cnt[TAP:0];
  end

  assign tap_bit  = bit_v[rate];
  assign tap_full = full_v[rate];
  assign active   = (rate != '0);

endmodule

// File: rtl/rtc_tap_divider.sv
module rtc_tap_divider
  import rtc_div_pkg::*;
#(
  parameter int STAGES = 15,
  parameter int RATE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tb_en,
  input  logic [2:0]        osc_ctl,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic              sqw_en,
  input  logic              pi_en,
  output logic              sqw,
  output logic              pi_evt,
  output logic              sec_tick
);

  chain_mode_e       mode;
  logic [STAGES-1:0] cnt;
  logic              tap_bit, tap_full, active;
  logic              pi_q, pi_d;

  assign mode = decode_osc(osc_ctl);

  rtc_div_chain #(.STAGES(STAGES)) i_chain (
    .clk       (clk),
    .rst_n     (rst_n),
    .tb_en     (tb_en),
    .mode      (mode),
    .cnt       (cnt),
    .wrap_tick (sec_tick)
  );

  rtc_tap_sel #(.STAGES(STAGES), .RATE_W(RATE_W)) i_tap (
    .cnt      (cnt),
    .rate     (rate_sel),
    .tap_bit  (tap_bit),
    .tap_full (tap_full),
    .active   (active)
  );

  // The tap falls on the advance that carries out of its low bits.
  always_comb begin
    pi_d = pi_en && active && (mode == CH_RUN) && tb_en && tap_full;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pi_q <= 1'b0;
    else        pi_q <= pi_d;
  end

  assign pi_evt = pi_q;
  assign sqw    = sqw_en && active && tap_bit;

  // R6: an event only follows an enabled, nonzero selection.
  p_pi_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pi_evt |-> $past(pi_en) && ($past(rate_sel) != '0));

  // R6: after an event under a steady selection, the selected tap is low.
  p_pi_tap_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pi_evt && $stable(rate_sel)) |-> !tap_bit);

  // R7: the square wave stays low while disabled or deselected.
  p_sqw_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!sqw_en || rate_sel == '0) |-> !sqw);

endmodule

// File: tb/test_rtc_tap_divider.sv
module test_rtc_tap_divider;

  localparam int CLK_PERIOD = 10;
  localparam int WRAP       = 32768;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tb_en;
  logic [2:0] osc_ctl;
  logic [3:0] rate_sel;
  logic       sqw_en, pi_en;
  logic       sqw, pi_evt, sec_tick;

  int checks   = 0;
  int failures = 0;
  int n        = 0;  // model chain count
  bit done     = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_tap_divider i_rtc_tap_divider (
    .clk      (clk),
    .rst_n    (rst_n),
    .tb_en    (tb_en),
    .osc_ctl  (osc_ctl),
    .rate_sel (rate_sel),
    .sqw_en   (sqw_en),
    .pi_en    (pi_en),
    .sqw      (sqw),
    .pi_evt   (pi_evt),
    .sec_tick (sec_tick)
  );

  function automatic int tap_k(input int c);
    if (c == 1) return 6;
    if (c == 2) return 7;
    return c - 2;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // One clock with the given time-base enable; model update and output checks.
  task automatic step(input bit te, input string tag);
    bit run, hold, tick_e, pi_e, sqw_e;
    int k;
    tb_en = te;
    @(posedge clk);
    @(negedge clk);
    run  = (osc_ctl == 3'b010);
    hold = (osc_ctl[2:1] == 2'b11);
    if (hold) n = 0;
    else if (run && te) n = (n + 1) % WRAP;
    k      = tap_k(int'(rate_sel));
    tick_e = run && te && (n == 0);
    pi_e   = pi_en && (rate_sel != 0) && run && te && ((n % (2 << k)) == 0);
    sqw_e  = sqw_en && (rate_sel != 0) && (((n >> k) & 1) == 1);
    chk(sec_tick == tick_e, {tag, " sec_tick"}, sec_tick, tick_e);
    chk(pi_evt == pi_e,     {tag, " pi_evt"},   pi_evt,   pi_e);
    chk(sqw == sqw_e,       {tag, " sqw"},      sqw,      sqw_e);
  endtask

  task automatic clear_chain();
    osc_ctl = 3'b111;
    step(1'b1, "R3 hold");
    osc_ctl = 3'b110;
    step(1'b1, "R3 hold");
    osc_ctl = 3'b010;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stim
    int ticks;
    rst_n = 1'b0; tb_en = 1'b0; osc_ctl = 3'b010;
    rate_sel = 4'd3; sqw_en = 1'b1; pi_en = 1'b1;
    repeat (3) @(negedge clk);
    // R1: outputs low in reset
    chk(sqw == 0 && pi_evt == 0 && sec_tick == 0, "R1 reset outputs", {sqw, pi_evt, sec_tick}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sqw == 0 && pi_evt == 0 && sec_tick == 0, "R1 after release", {sqw, pi_evt, sec_tick}, 0);

    // R5/R6: sweep every rate code over two periods of its tap
    for (int c = 0; c < 16; c++) begin
      rate_sel = 4'(c);
      clear_chain();
      if (c == 0) begin
        for (int i = 0; i < 64; i++) step(1'b1, "R7 code0");
      end else begin
        for (int i = 0; i < (4 << tap_k(c)); i++) step(1'b1, "R5 R6 sweep");
      end
    end
    // code 15 ran 32768 pulses from a clear: sec_tick checked at the last (R3)

    // R7: enables off with an active code; chain still advances
    rate_sel = 4'd4; sqw_en = 1'b0; pi_en = 1'b0;
    clear_chain();
    for (int i = 0; i < 64; i++) step(1'b1, "R7 disabled");
    sqw_en = 1'b1; pi_en = 1'b1;
    for (int i = 0; i < 16; i++) step(1'b1, "R7 reenabled");

    // R2: gapped time base; R4: stop patterns freeze without loss
    rate_sel = 4'd5;
    clear_chain();
    for (int i = 0; i < 600; i++) step(i[0], "R2 gapped");
    for (int p = 0; p < 8; p++) begin
      if (p == 2 || p == 6 || p == 7) continue;
      osc_ctl = 3'(p);
      for (int i = 0; i < 50; i++) step(1'b1, "R4 stopped");
    end
    osc_ctl = 3'b010;
    ticks = 0;
    for (int i = 0; i < WRAP - 300; i++) begin
      step(1'b1, "R2 R4 resume");
      if (sec_tick) ticks++;
    end
    chk(ticks == 1, "R4 one tick after resume", ticks, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule